// File: doc/BRIEF.md
# Floppy Controller Host Register Front End

This block is the programmed-I/O face of a floppy disk controller. A host reaches it through a small register window selected by a 3-bit offset. Through that window the host sets the track and sector registers and issues commands. It moves sector data a byte at a time through a single data port, and it polls a status byte, a wait port and a DMA status port. Byte transfers go to and from a 128-byte sector buffer that sits on the media side. The buffer is a synchronous memory with one cycle of read latency. The block also emits a one-cycle strobe when a written sector is ready to be committed.

Each access of the data port moves the transfer on by one byte. On reads the next byte is taken from the buffer. On writes the byte goes into the buffer at the current index. The controller keeps BUSY, DRQ and the interrupt request up to date as the transfer runs. Three operations are supported: a sector read, a sector write and a read of a six-byte ID field. Any other command code completes at once. Read data appears on `host_rdata`, qualified by `host_rvalid`, in the cycle after the access.

Top module: `fdc_host_regs`

## Requirements
- R1: After reset the track register reads 0x00, the sector register 0x01, the data register 0x00, status 0x00, the wait port 0x80 (no interrupt pending) and `drv_ctl` 0x00.
- R2: Read offsets decode as 0 status, 1 track, 2 sector, 3 data, 4 wait, 5 DMA status; offsets 6 and 7 read 0xFF. Every read returns its value with `host_rvalid` one cycle after the access, and reads of track and sector change nothing.
- R3: A command whose upper nibble is 0x8 or 0x9 starts a sector read. Status becomes 0x03 (bit 0 BUSY, bit 1 DRQ) and the interrupt clears. Successive data-port reads return buffer bytes 0 to 127 in order, including back-to-back reads.
- R4: During a sector read, every data read but the 128th leaves status at 0x03. The 128th ends the operation with status 0x00, the interrupt set and the byte index returned to 0.
- R5: An upper nibble of 0xA or 0xB starts a sector write. Each data-port write stores its byte at the current buffer index. In the cycle after the 128th write, `sector_commit` is high for exactly one cycle, and the operation then ends with the interrupt set and status 0x00.
- R6: If `commit_fail` is high during the `sector_commit` cycle, the final status is 0x20 (write fault) instead of 0x00.
- R7: An upper nibble of 0xC starts an ID read of six data-port reads: the track register, 0x00, the sector register, the length code (default 0x00), then buffer bytes 4 and 5. The interrupt is raised after the sixth.
- R8: The wait port reads 0x00 while the interrupt is set and 0x80 otherwise. The DMA status port always reads 0x00.
- R9: Reading status returns the value held before the read and clears the interrupt.
- R10: Any command write aborts the running operation and clears the byte index. Command codes outside the three transfer groups end at once with status 0x00 and the interrupt set.
- R11: BUSY and the interrupt are never set together, and BUSY never falls without the interrupt rising.
- R12: A write to offset 4 loads `drv_ctl`. A write to offset 5 changes neither `drv_ctl`, track nor sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_wr | input | 1 | 1 = write access, 0 = read access |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after a read access |
| buf_addr | output | 7 | Sector buffer byte index |
| buf_we | output | 1 | Sector buffer write enable |
| buf_wdata | output | 8 | Sector buffer write data |
| buf_rdata | input | 8 | Sector buffer read data, one cycle after buf_addr |
| sector_commit | output | 1 | One-cycle strobe: buffered sector ready to store |
| commit_fail | input | 1 | Media reports that the commit failed, sampled with sector_commit |
| cur_track | output | 8 | Track register for the media side |
| cur_sector | output | 8 | Sector register for the media side |
| drv_ctl | output | 8 | Last drive select byte written |

## Verification
The in-line properties watch, on every cycle, that BUSY and the interrupt stay mutually exclusive and that BUSY only drops when the interrupt rises. They also check that the ID-read index stays inside the six-byte frame, that a commit strobe always follows a buffer write, that read data is valid only after a read access, and that the wait port mirrors the interrupt. Only the bench scenarios can show the byte order of a 128-byte read and of an ID frame, and the buffer contents after a write. The same holds for status after a failed commit, for abort clearing the index, for status reads clearing the interrupt, and for offset 5 writes being ignored.

// File: rtl/fdc_pkg.sv
// Shared definitions for the floppy controller host front end.
// Assumes a byte-wide host window with a 3-bit register offset.
package fdc_pkg;
    localparam logic [2:0] PORT_STAT = 3'd0;
    localparam logic [2:0] PORT_TRK  = 3'd1;
    localparam logic [2:0] PORT_SEC  = 3'd2;
    localparam logic [2:0] PORT_DATA = 3'd3;
    localparam logic [2:0] PORT_WAIT = 3'd4;
    localparam logic [2:0] PORT_DMA  = 3'd5;

    localparam int ST_BUSY   = 0;
    localparam int ST_DRQ    = 1;
    localparam int ST_WFAULT = 5;

    // leading bytes of an ID frame that come from registers, not the buffer
    localparam int ID_REG_BYTES = 4;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_RDSEC,
        OP_WRSEC,
        OP_RDID,
        OP_COMMIT
    } op_e;

    // Map a command byte to the operation it starts
    function automatic op_e decode_cmd(input logic [7:0] cmd);
        case (cmd[7:4])
            4'h8, 4'h9: decode_cmd = OP_RDSEC;
            4'hA, 4'hB: decode_cmd = OP_WRSEC;
            4'hC:       decode_cmd = OP_RDID;
            default:    decode_cmd = OP_IDLE;
        endcase
    endfunction
endpackage

// File: rtl/fdc_xfer_seq.sv
// Transfer sequencer: owns the operation state, the byte index, the status
// byte and the interrupt request. Assumes at most one host access per cycle.
module fdc_xfer_seq
    import fdc_pkg::*;
#(
    parameter int SECTOR_BYTES = 128,
    parameter int ID_BYTES     = 6,
    parameter int CW           = $clog2(SECTOR_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [7:0]    cmd_val,
    input  logic          data_rd,
    input  logic          data_wr,
    input  logic          stat_rd,
    input  logic          commit_fail,
    output logic [CW-1:0] idx,
    output logic [7:0]    status,
    output logic          intrq,
    output logic          buf_we,
    output logic          fetch,
    output logic          id_local,
    output logic          sector_commit
);
    localparam logic [CW-1:0] LAST_SEC = CW'(SECTOR_BYTES - 1);
    localparam logic [CW-1:0] LAST_ID  = CW'(ID_BYTES - 1);
    localparam logic [CW-1:0] ID_SPLIT = CW'(ID_REG_BYTES);
    localparam logic [7:0]    ST_RUN   = 8'h03;

    op_e           op_q;
    logic [CW-1:0] cnt_q;
    logic [7:0]    status_q;
    logic          intrq_q;

    // Advance the operation on commands and data-port accesses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_IDLE;
            cnt_q    <= '0;
            status_q <= '0;
            intrq_q  <= 1'b0;
        end else begin
            if (stat_rd) intrq_q <= 1'b0;
            if (cmd_we) begin
                cnt_q <= '0;
                op_q  <= decode_cmd(cmd_val);
                if (decode_cmd(cmd_val) == OP_IDLE) begin
                    status_q <= '0;
                    intrq_q  <= 1'b1;
                end else begin
                    status_q <= ST_RUN;
                    intrq_q  <= 1'b0;
                end
            end else if (op_q == OP_COMMIT) begin
                op_q     <= OP_IDLE;
                status_q <= commit_fail ? (8'h01 << ST_WFAULT) : 8'h00;
                intrq_q  <= 1'b1;
            end else if (data_rd && op_q == OP_RDSEC) begin
                if (cnt_q == LAST_SEC) begin
                    op_q     <= OP_IDLE;
                    cnt_q    <= '0;
                    status_q <= '0;
                    intrq_q  <= 1'b1;
                end else begin
                    cnt_q            <= cnt_q + 1'b1;
                    status_q[ST_DRQ] <= 1'b1;
                end
            end else if (data_rd && op_q == OP_RDID) begin
                if (cnt_q == LAST_ID) begin
                    op_q     <= OP_IDLE;
                    cnt_q    <= '0;
                    status_q <= '0;
                    intrq_q  <= 1'b1;
                end else begin
                    cnt_q            <= cnt_q + 1'b1;
                    status_q[ST_DRQ] <= 1'b1;
                end
            end else if (data_wr && op_q == OP_WRSEC) begin
                if (cnt_q == LAST_SEC) begin
                    op_q  <= OP_COMMIT;
                    cnt_q <= '0;
                end else begin
                    cnt_q            <= cnt_q + 1'b1;
                    status_q[ST_DRQ] <= 1'b1;
                end
            end
        end
    end

    // Buffer-side strobes derived from the state
    always_comb begin
        buf_we        = data_wr && (op_q == OP_WRSEC);
        fetch         = data_rd && ((op_q == OP_RDSEC) ||
                        ((op_q == OP_RDID) && (cnt_q >= ID_SPLIT)));
        id_local      = (op_q == OP_RDID) && (cnt_q < ID_SPLIT);
        sector_commit = (op_q == OP_COMMIT);
    end

    assign idx    = cnt_q;
    assign status = status_q;
    assign intrq  = intrq_q;

    // R11
    busy_irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_q[ST_BUSY] && intrq_q));
    // R11
    busy_end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_q[ST_BUSY]) |-> intrq_q);
    // R7
    id_index_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_RDID) |-> (cnt_q <= LAST_ID));
    // R5
    commit_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sector_commit |-> $past(buf_we));
endmodule

// File: rtl/fdc_port_mux.sv
// Read-side register selector: picks the byte a host read of each offset
// returns. Purely combinational; assumes caller registers the result.
module fdc_port_mux
    import fdc_pkg::*;
(
    input  logic [2:0] port,
    input  logic [7:0] status,
    input  logic [7:0] track,
    input  logic [7:0] sector,
    input  logic [7:0] data_view,
    input  logic       intrq,
    output logic [7:0] value
);
    // Select the register behind the offset
    always_comb begin
        case (port)
            PORT_STAT: value = status;
            PORT_TRK:  value = track;
            PORT_SEC:  value = sector;
            PORT_DATA: value = data_view;
            PORT_WAIT: value = intrq ? 8'h00 : 8'h80;
            PORT_DMA:  value = 8'h00;
            default:   value = 8'hFF;
        endcase
    end
endmodule

// File: rtl/fdc_host_regs.sv
// Host register front end of a floppy controller: decodes the 3-bit offset,
// holds track, sector, data and drive-control registers, and returns read
// data one cycle after the access. Assumes the sector buffer has one cycle
// of read latency and that the host issues at most one access per cycle.
module fdc_host_regs
    import fdc_pkg::*;
#(
    parameter int         SECTOR_BYTES = 128,
    parameter int         ID_BYTES     = 6,
    parameter logic [7:0] LEN_CODE     = 8'h00,
    parameter int         AW           = $clog2(SECTOR_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_sel,
    input  logic          host_wr,
    input  logic [2:0]    host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    output logic          host_rvalid,
    output logic [AW-1:0] buf_addr,
    output logic          buf_we,
    output logic [7:0]    buf_wdata,
    input  logic [7:0]    buf_rdata,
    output logic          sector_commit,
    input  logic          commit_fail,
    output logic [7:0]    cur_track,
    output logic [7:0]    cur_sector,
    output logic [7:0]    drv_ctl
);
    logic       acc_rd, acc_wr;
    logic       cmd_we, data_rd, data_wr, stat_rd;
    logic [7:0] track_q, sector_q, data_q, drv_q, rdata_q;
    logic       fetch_pend_q, rvalid_q;
    logic [7:0] status, id_byte, data_view, mux_val;
    logic       intrq, fetch, id_local;
    logic [AW-1:0] idx;

    // Decode the access into per-port strobes
    always_comb begin
        acc_rd  = host_sel && !host_wr;
        acc_wr  = host_sel && host_wr;
        cmd_we  = acc_wr && (host_addr == PORT_STAT);
        data_wr = acc_wr && (host_addr == PORT_DATA);
        data_rd = acc_rd && (host_addr == PORT_DATA);
        stat_rd = acc_rd && (host_addr == PORT_STAT);
    end

    fdc_xfer_seq #(
        .SECTOR_BYTES(SECTOR_BYTES),
        .ID_BYTES    (ID_BYTES),
        .CW          (AW)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_we       (cmd_we),
        .cmd_val      (host_wdata),
        .data_rd      (data_rd),
        .data_wr      (data_wr),
        .stat_rd      (stat_rd),
        .commit_fail  (commit_fail),
        .idx          (idx),
        .status       (status),
        .intrq        (intrq),
        .buf_we       (buf_we),
        .fetch        (fetch),
        .id_local     (id_local),
        .sector_commit(sector_commit)
    );

    // Form the register-sourced bytes of an ID frame
    always_comb begin
        case (idx[1:0])
            2'd0:    id_byte = track_q;
            2'd1:    id_byte = 8'h00;
            2'd2:    id_byte = sector_q;
            default: id_byte = LEN_CODE;
        endcase
        if (id_local)          data_view = id_byte;
        else if (fetch_pend_q) data_view = buf_rdata;
        else                   data_view = data_q;
    end

    fdc_port_mux u_mux (
        .port     (host_addr),
        .status   (status),
        .track    (track_q),
        .sector   (sector_q),
        .data_view(data_view),
        .intrq    (intrq),
        .value    (mux_val)
    );

    // Host-writable registers and the data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            track_q  <= 8'h00;
            sector_q <= 8'h01;
            data_q   <= 8'h00;
            drv_q    <= 8'h00;
        end else begin
            if (fetch_pend_q) data_q <= buf_rdata;
            if (data_wr) data_q <= host_wdata;
            else if (data_rd && id_local) data_q <= id_byte;
            if (acc_wr && host_addr == PORT_TRK)  track_q  <= host_wdata;
            if (acc_wr && host_addr == PORT_SEC)  sector_q <= host_wdata;
            if (acc_wr && host_addr == PORT_WAIT) drv_q    <= host_wdata;
        end
    end

    // Read-return pipeline, one cycle after the access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q      <= 8'h00;
            rvalid_q     <= 1'b0;
            fetch_pend_q <= 1'b0;
        end else begin
            rvalid_q     <= acc_rd;
            fetch_pend_q <= fetch;
            if (acc_rd) rdata_q <= mux_val;
        end
    end

    assign host_rdata  = fetch_pend_q ? buf_rdata : rdata_q;
    assign host_rvalid = rvalid_q;
    assign buf_addr    = idx;
    assign buf_wdata   = host_wdata;
    assign cur_track   = track_q;
    assign cur_sector  = sector_q;
    assign drv_ctl     = drv_q;

    // R2
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(host_sel && !host_wr));
    // R8
    wait_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && $past(host_addr) == PORT_WAIT) |->
        (host_rdata == ($past(intrq) ? 8'h00 : 8'h80)));
endmodule

// File: tb/fdc_host_regs_test.sv
module fdc_host_regs_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0, host_wr = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       host_rvalid;
    logic [6:0] buf_addr;
    logic       buf_we;
    logic [7:0] buf_wdata;
    logic [7:0] buf_rdata = 8'h00;
    logic       sector_commit;
    logic       commit_fail = 1'b0;
    logic [7:0] cur_track, cur_sector, drv_ctl;

    logic [7:0] mem [128];
    int         commits = 0;
    int         checks = 0, fails = 0;
    bit         done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fdc_host_regs uut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .buf_addr(buf_addr), .buf_we(buf_we),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .sector_commit(sector_commit),
        .commit_fail(commit_fail), .cur_track(cur_track), .cur_sector(cur_sector),
        .drv_ctl(drv_ctl)
    );

    // Sector buffer model with one cycle read latency
    always @(posedge clk) begin
        if (buf_we) mem[buf_addr] <= buf_wdata;
        buf_rdata <= mem[buf_addr];
        if (sector_commit) commits <= commits + 1;
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: pop expected read data as results appear
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2: actual %02h expected no read data", host_rdata);
            end else begin
                check(host_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic put(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    endtask

    task automatic get(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'(i * 3 + 5);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R2 port decode
        get(3'd0, 8'h00, "R1 status");
        get(3'd1, 8'h00, "R1 track");
        get(3'd2, 8'h01, "R1 sector");
        get(3'd3, 8'h00, "R1 data");
        get(3'd4, 8'h80, "R1 wait");
        get(3'd5, 8'h00, "R8 dma");
        get(3'd6, 8'hFF, "R2 undefined 6");
        get(3'd7, 8'hFF, "R2 undefined 7");
        idle();
        check(drv_ctl, 8'h00, "R1 drv_ctl");

        // R2 track/sector reads have no side effect
        put(3'd1, 8'h22);
        put(3'd2, 8'h07);
        get(3'd1, 8'h22, "R2 track");
        get(3'd1, 8'h22, "R2 track again");
        get(3'd2, 8'h07, "R2 sector");
        get(3'd2, 8'h07, "R2 sector again");
        idle();
        check(cur_track, 8'h22, "R2 cur_track");

        // R3/R4 sector read
        put(3'd0, 8'h88);
        get(3'd0, 8'h03, "R3 status start");
        get(3'd4, 8'h80, "R11 wait while busy");
        for (int i = 0; i < 128; i++) begin
            get(3'd3, mem[i], "R3 read byte");
            if (i == 60) get(3'd0, 8'h03, "R4 status mid");
        end
        get(3'd4, 8'h00, "R8 wait after read");
        get(3'd0, 8'h00, "R4 status end");
        get(3'd4, 8'h80, "R9 interrupt cleared");
        get(3'd3, mem[127], "R4 data holds last byte");
        idle();

        // R5 sector write
        put(3'd0, 8'hA0);
        for (int i = 0; i < 128; i++) put(3'd3, 8'(i ^ 8'h5A));
        idle();
        check({7'd0, sector_commit}, 8'h01, "R5 commit strobe");
        idle();
        check({7'd0, sector_commit}, 8'h00, "R5 commit one cycle");
        check(8'(commits), 8'h01, "R5 commit count");
        for (int i = 0; i < 128; i++) check(mem[i], 8'(i ^ 8'h5A), "R5 buffer byte");
        get(3'd4, 8'h00, "R5 wait after write");
        get(3'd0, 8'h00, "R5 status end");
        idle();

        // R6 failed commit
        commit_fail = 1'b1;
        put(3'd0, 8'hB4);
        for (int i = 0; i < 128; i++) put(3'd3, 8'(i));
        idle();
        idle();
        commit_fail = 1'b0;
        get(3'd0, 8'h20, "R6 write fault");
        idle();

        // R7 ID read
        mem[4] = 8'hC1;
        mem[5] = 8'h9E;
        put(3'd0, 8'hC0);
        get(3'd3, 8'h22, "R7 id track");
        get(3'd3, 8'h00, "R7 id zero");
        get(3'd3, 8'h07, "R7 id sector");
        get(3'd3, 8'h00, "R7 id length");
        get(3'd3, 8'hC1, "R7 id crc1");
        get(3'd3, 8'h9E, "R7 id crc2");
        get(3'd4, 8'h00, "R7 interrupt after frame");
        get(3'd0, 8'h00, "R7 status end");
        idle();

        // R10 abort and restart clears index; immediate command
        for (int i = 0; i < 128; i++) mem[i] = 8'(8'hF0 - i);
        put(3'd0, 8'h80);
        get(3'd3, mem[0], "R10 first");
        get(3'd3, mem[1], "R10 second");
        get(3'd3, mem[2], "R10 third");
        put(3'd0, 8'h90);
        get(3'd3, mem[0], "R10 index cleared");
        get(3'd0, 8'h03, "R10 still busy");
        put(3'd0, 8'h10);
        get(3'd4, 8'h00, "R10 immediate interrupt");
        get(3'd0, 8'h00, "R10 immediate status");
        idle();

        // R12 drive select and ignored offset 5 write
        put(3'd4, 8'h5A);
        idle();
        check(drv_ctl, 8'h5A, "R12 drv_ctl load");
        put(3'd5, 8'hFF);
        idle();
        check(drv_ctl, 8'h5A, "R12 drv_ctl after ext write");
        get(3'd1, 8'h22, "R12 track after ext write");
        get(3'd2, 8'h07, "R12 sector after ext write");
        get(3'd5, 8'h00, "R8 dma idle");
        idle();
        repeat (3) idle();

        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R2: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule